// File: doc/BRIEF.md
# GPIO Port Controller with Four-Way Pin Multiplexing

This block owns the configuration of one port of up to 32 pins. Each pin can be driven by the GPIO logic or handed to one of four internal peripheral functions. A simple register interface with address, write data, write strobe and combinational read data changes that configuration. Every configuration field is a per-pin state vector, and software modifies it through a pair of registers: writing ones to the set register sets the matching bits, and writing ones to the clear register clears them. A single write therefore touches only the pins whose data bits are 1, and software never needs a read-modify-write.

The outputs are per-pin pad controls: drive enable, drive value, pull-up and pull-down. There is also a vector of per-pin interrupt enables that a separate interrupt unit consumes. The actual pad level passes through a two-flop synchronizer and can always be read back, whichever function owns the pin. An open-drain mode turns any driver, GPIO or peripheral, into a pull-low-only driver. Pull-up and pull-down exclude each other in hardware.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Register map (word addresses, 5 bits). Seven set/clear groups sit at base 4k, with k = 0 ownership, 1 output enable, 2 output data, 3 pull-up, 4 pull-down, 5 open-drain, 6 interrupt enable. Base+0 is set, base+1 is clear and base+2 reads the state vector. 0x1C and 0x1D are the read/write select-low and select-high registers, and 0x1E reads the synchronized pad level. After reset, ownership and pull-up are all ones and every other vector, including both selects, is zero. Unmapped reads return 0.
- R2: A write to the ownership set register gives the pins whose data bits are 1 to GPIO. A write to its clear register gives those pins to their peripheral function. Pins written with 0 keep their state.
- R3: A pin not owned by GPIO takes drive value and enable from peripheral function f = {select-high bit, select-low bit}: 0 is A, 1 is B (low bit alone), 2 is C (high bit alone), 3 is D. These come from bit f*N+p of the peripheral output and enable buses.
- R4: A GPIO-owned pin drives its output-data bit with its output-enable bit. Writes to output data take effect while the pin is not an output and appear once it is enabled.
- R5: Output-enable, output-data, open-drain and interrupt-enable vectors follow the same masked set/clear rule as ownership.
- R6: Setting pull-down on a pin also clears its pull-up, and setting pull-up also clears its pull-down. The two pad pull outputs are never both 1 on one pin.
- R7: With open-drain on, a pin is driven only while its selected value is 0: pad enable = selected enable AND NOT value, and pad value = 0. With open-drain off, both pass through.
- R8: The interrupt-enable vector appears on irq_en_o.
- R9: The pad status register shows the pad input sampled through two flops. A change made before a rising edge is visible after the second rising edge, whatever the pin's ownership.
- R10: Writes to state-readback addresses (base+2), to base+3 and to the pad status address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Word address |
| wdata | input | N_PINS | Write data, one bit per pin |
| rdata | output | N_PINS | Read data for addr |
| pad_i | input | N_PINS | Pad input level |
| pad_oe_o | output | N_PINS | Pad drive enable |
| pad_do_o | output | N_PINS | Pad drive value |
| pad_pu_o | output | N_PINS | Pull-up enable |
| pad_pd_o | output | N_PINS | Pull-down enable |
| irq_en_o | output | N_PINS | Per-pin interrupt enable |
| periph_out_i | input | 4*N_PINS | Peripheral drive values, function f at bits f*N_PINS+p |
| periph_oe_i | input | 4*N_PINS | Peripheral drive enables, same layout |

## Verification
Every set/clear group is swept over all 256 masks of an 8-pin build, with the clear mask a fixed XOR of the set mask. This exposes a pin that ignores its mask bit, a clear that leaks into its neighbours or a swapped pair. The pull groups run with the interlock active, which separates plain set/clear from cross-clearing. Random sweeps of ownership, select, open-drain and peripheral buses compare every pad pin against an arithmetic model, which tells wrong function decoding apart from wrong open-drain gating. Pad toggles read at zero, one and two edges pin down the synchronizer depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W    = 5;
  localparam int MAX_PINS  = 32;
  localparam int N_PAIRS   = 7;
  localparam int N_FUNC    = 4;

  localparam int G_OWN = 0;
  localparam int G_OE  = 1;
  localparam int G_DO  = 2;
  localparam int G_PU  = 3;
  localparam int G_PD  = 4;
  localparam int G_OD  = 5;
  localparam int G_IE  = 6;

  localparam int OFF_SET  = 0;
  localparam int OFF_CLR  = 1;
  localparam int OFF_STAT = 2;

  localparam logic [ADDR_W-1:0] A_SEL_LO = 5'h1C;
  localparam logic [ADDR_W-1:0] A_SEL_HI = 5'h1D;
  localparam logic [ADDR_W-1:0] A_PAD    = 5'h1E;

  function automatic logic [ADDR_W-1:0] grp_addr(int grp, int off);
    return ADDR_W'(4 * grp + off);
  endfunction

  // set has precedence over clear for the same bit
  function automatic logic [MAX_PINS-1:0] sc_next(logic [MAX_PINS-1:0] cur,
                                                   logic [MAX_PINS-1:0] set_m,
                                                   logic [MAX_PINS-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  function automatic logic [1:0] func_index(logic sel_lo, logic sel_hi);
    return {sel_hi, sel_lo};
  endfunction

  // open-drain gating: returns {enable, value}
  function automatic logic [1:0] od_gate(logic od, logic en, logic val);
    if (od) return {en & ~val, 1'b0};
    return {en, val};
  endfunction
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_pkg::*;
#(
  parameter int N_PINS  = 32,
  parameter bit RST_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] set_m,
  input  logic [N_PINS-1:0] clr_m,
  output logic [N_PINS-1:0] q
);
  logic [N_PINS-1:0] q_nxt;

  always_comb begin
    q_nxt = N_PINS'(sc_next(MAX_PINS'(q), MAX_PINS'(set_m), MAX_PINS'(clr_m)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {N_PINS{RST_ONE}};
    else        q <= q_nxt;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] d,
  output logic [N_PINS-1:0] q
);
  logic [N_PINS-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic [N_PINS-1:0]        own,
  input  logic [N_PINS-1:0]        sel_lo,
  input  logic [N_PINS-1:0]        sel_hi,
  input  logic [N_PINS-1:0]        gp_oe,
  input  logic [N_PINS-1:0]        gp_do,
  input  logic [N_PINS-1:0]        od,
  input  logic [N_FUNC*N_PINS-1:0] periph_out,
  input  logic [N_FUNC*N_PINS-1:0] periph_oe,
  output logic [N_PINS-1:0]        pad_oe,
  output logic [N_PINS-1:0]        pad_do
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [1:0]        fn;
    logic [N_FUNC-1:0] f_out;
    logic [N_FUNC-1:0] f_oe;
    logic              sel_en;
    logic              sel_val;
    logic [1:0]        gated;

    for (genvar f = 0; f < N_FUNC; f++) begin : g_fn
      assign f_out[f] = periph_out[f*N_PINS + p];
      assign f_oe[f]  = periph_oe[f*N_PINS + p];
    end

    assign fn      = func_index(sel_lo[p], sel_hi[p]);
    assign sel_val = own[p] ? gp_do[p] : f_out[fn];
    assign sel_en  = own[p] ? gp_oe[p] : f_oe[fn];
    assign gated   = od_gate(od[p], sel_en, sel_val);
    assign pad_oe[p] = gated[1];
    assign pad_do[p] = gated[0];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N_PINS-1:0]        wdata,
  output logic [N_PINS-1:0]        rdata,
  input  logic [N_PINS-1:0]        pad_i,
  output logic [N_PINS-1:0]        pad_oe_o,
  output logic [N_PINS-1:0]        pad_do_o,
  output logic [N_PINS-1:0]        pad_pu_o,
  output logic [N_PINS-1:0]        pad_pd_o,
  output logic [N_PINS-1:0]        irq_en_o,
  input  logic [N_FUNC*N_PINS-1:0] periph_out_i,
  input  logic [N_FUNC*N_PINS-1:0] periph_oe_i
);
  logic [N_PAIRS-1:0] hit_set;
  logic [N_PAIRS-1:0] hit_clr;
  logic [N_PINS-1:0]  set_v   [N_PAIRS];
  logic [N_PINS-1:0]  raw_clr [N_PAIRS];
  logic [N_PINS-1:0]  clr_v   [N_PAIRS];
  logic [N_PINS-1:0]  st      [N_PAIRS];

  logic [N_PINS-1:0] st_own, st_oe, st_do, st_pu, st_pd, st_od, st_ie;
  logic [N_PINS-1:0] sel_lo, sel_hi;
  logic [N_PINS-1:0] pad_sync;
  logic              wr_sel_lo, wr_sel_hi;

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_grp
    assign hit_set[k] = wr_en && (addr == grp_addr(k, OFF_SET));
    assign hit_clr[k] = wr_en && (addr == grp_addr(k, OFF_CLR));
    assign set_v[k]   = hit_set[k] ? wdata : '0;
    assign raw_clr[k] = hit_clr[k] ? wdata : '0;

    if (k == G_PU) begin : g_pu_lock
      assign clr_v[k] = raw_clr[k] | set_v[G_PD];
    end else if (k == G_PD) begin : g_pd_lock
      assign clr_v[k] = raw_clr[k] | set_v[G_PU];
    end else begin : g_plain
      assign clr_v[k] = raw_clr[k];
    end

    gpio_cfg_reg #(
      .N_PINS (N_PINS),
      .RST_ONE((k == G_OWN) || (k == G_PU))
    ) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .set_m(set_v[k]),
      .clr_m(clr_v[k]),
      .q    (st[k])
    );
  end

  assign st_own = st[G_OWN];
  assign st_oe  = st[G_OE];
  assign st_do  = st[G_DO];
  assign st_pu  = st[G_PU];
  assign st_pd  = st[G_PD];
  assign st_od  = st[G_OD];
  assign st_ie  = st[G_IE];

  assign wr_sel_lo = wr_en && (addr == A_SEL_LO);
  assign wr_sel_hi = wr_en && (addr == A_SEL_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo <= '0;
      sel_hi <= '0;
    end else begin
      if (wr_sel_lo) sel_lo <= wdata;
      if (wr_sel_hi) sel_hi <= wdata;
    end
  end

  gpio_sync #(.N_PINS(N_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_i),
    .q    (pad_sync)
  );

  gpio_pin_mux #(.N_PINS(N_PINS)) u_mux (
    .own       (st_own),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .gp_oe     (st_oe),
    .gp_do     (st_do),
    .od        (st_od),
    .periph_out(periph_out_i),
    .periph_oe (periph_oe_i),
    .pad_oe    (pad_oe_o),
    .pad_do    (pad_do_o)
  );

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_PAIRS; k++) begin
      if (addr == grp_addr(k, OFF_STAT)) rdata = st[k];
    end
    if (addr == A_SEL_LO) rdata = sel_lo;
    if (addr == A_SEL_HI) rdata = sel_hi;
    if (addr == A_PAD)    rdata = pad_sync;
  end

  assign pad_pu_o = st_pu;
  assign pad_pd_o = st_pd;
  assign irq_en_o = st_ie;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_PINS-1:0] wdata,
  input logic [N_PINS-1:0] st_own,
  input logic [N_PINS-1:0] st_oe,
  input logic [N_PINS-1:0] st_ie,
  input logic [N_PINS-1:0] st_od,
  input logic [N_PINS-1:0] pad_pu_o,
  input logic [N_PINS-1:0] pad_pd_o,
  input logic [N_PINS-1:0] pad_do_o
);
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_o & pad_pd_o) == '0); // R6

  AST_OWN_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == grp_addr(G_OWN, OFF_SET)) |=>
      ((st_own & $past(wdata)) == $past(wdata))); // R2

  AST_OWN_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == grp_addr(G_OWN, OFF_CLR)) |=>
      ((st_own & $past(wdata)) == '0)); // R2

  AST_OE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == grp_addr(G_OE, OFF_SET)) |=>
      (((st_oe ^ $past(st_oe)) & ~$past(wdata)) == '0)); // R5

  AST_IE_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == grp_addr(G_IE, OFF_CLR)) |=>
      ((st_ie & $past(wdata)) == '0)); // R8

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do_o & st_od) == '0); // R7

  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == grp_addr(G_OE, OFF_STAT)) |=> $stable(st_oe)); // R10
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .st_own  (st_own),
  .st_oe   (st_oe),
  .st_ie   (st_ie),
  .st_od   (st_od),
  .pad_pu_o(pad_pu_o),
  .pad_pd_o(pad_pd_o),
  .pad_do_o(pad_do_o)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [4:0]     addr = '0;
  logic [N-1:0]   wdata = '0;
  logic [N-1:0]   rdata;
  logic [N-1:0]   pad_i = '0;
  logic [N-1:0]   pad_oe_o, pad_do_o, pad_pu_o, pad_pd_o, irq_en_o;
  logic [4*N-1:0] periph_out_i = '0;
  logic [4*N-1:0] periph_oe_i = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the state vectors
  logic [N-1:0] m_g [7];
  logic [N-1:0] m_slo, m_shi;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.N_PINS(N)) i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_i(pad_i), .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o),
    .pad_pu_o(pad_pu_o), .pad_pd_o(pad_pd_o), .irq_en_o(irq_en_o),
    .periph_out_i(periph_out_i), .periph_oe_i(periph_oe_i));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ga(int g, int off);
    return 5'(g * 4 + off);
  endfunction

  // model update, written from the requirements
  task automatic model_wr(logic [4:0] a, logic [N-1:0] d);
    int g = int'(a) / 4;
    int off = int'(a) % 4;
    if (g < 7 && off == 0) begin
      m_g[g] = m_g[g] | d;
      if (g == 3) m_g[4] = m_g[4] & ~d;
      if (g == 4) m_g[3] = m_g[3] & ~d;
    end else if (g < 7 && off == 1) begin
      m_g[g] = m_g[g] & ~d;
    end else if (a == 5'h1C) m_slo = d;
    else if (a == 5'h1D) m_shi = d;
  endtask

  task automatic wr(logic [4:0] a, logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(logic [4:0] a, output logic [N-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic check_state(string req);
    logic [N-1:0] v;
    for (int g = 0; g < 7; g++) begin
      rd(ga(g, 2), v);
      chk(req, 32'(v), 32'(m_g[g]));
    end
    rd(5'h1C, v); chk(req, 32'(v), 32'(m_slo));
    rd(5'h1D, v); chk(req, 32'(v), 32'(m_shi));
    chk({req, "/R6 pull-up pin"}, 32'(pad_pu_o), 32'(m_g[3]));
    chk({req, "/R6 pull-down pin"}, 32'(pad_pd_o), 32'(m_g[4]));
    chk({req, "/R8 irq_en_o"}, 32'(irq_en_o), 32'(m_g[6]));
  endtask

  task automatic check_pads(string req);
    logic [N-1:0] e_oe, e_do;
    for (int p = 0; p < N; p++) begin
      int f = {m_shi[p], m_slo[p]};
      logic en = m_g[0][p] ? m_g[1][p] : periph_oe_i[f*N + p];
      logic v  = m_g[0][p] ? m_g[2][p] : periph_out_i[f*N + p];
      e_oe[p] = m_g[5][p] ? (en & ~v) : en;
      e_do[p] = m_g[5][p] ? 1'b0 : v;
    end
    chk({req, " pad_oe"}, 32'(pad_oe_o), 32'(e_oe));
    chk({req, " pad_do"}, 32'(pad_do_o), 32'(e_do));
  endtask

  task automatic load(int g, logic [N-1:0] v);
    wr(ga(g, 1), '1);
    wr(ga(g, 0), v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    for (int g = 0; g < 7; g++) m_g[g] = '0;
    m_g[0] = '1; m_g[3] = '1; m_slo = '0; m_shi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and unmapped read
    check_state("R1 reset");
    rd(5'h03, v); chk("R1 unmapped read", 32'(v), 32'h0);
    rd(5'h1F, v); chk("R1 unmapped read", 32'(v), 32'h0);

    // R2 R5 R6 R8: exhaustive mask sweep per group
    for (int g = 0; g < 7; g++) begin
      for (int m = 0; m < 256; m++) begin
        wr(ga(g, 0), N'(m));
        wr(ga(g, 1), N'(m) ^ 8'h5A);
        rd(ga(g, 2), v);
        chk(g == 0 ? "R2 own mask" : (g == 3 || g == 4) ? "R6 pull mask" :
            g == 6 ? "R8 ie mask" : "R5 mask", 32'(v), 32'(m_g[g]));
      end
      check_state("R5 after sweep");
    end

    // R6 interlock spot checks
    load(3, 8'hF0);
    wr(ga(4, 0), 8'h3C);
    check_state("R6 pd set clears pu");
    wr(ga(3, 0), 8'h0F);
    check_state("R6 pu set clears pd");

    // R10 writes to readback and unmapped addresses
    for (int g = 0; g < 7; g++) begin
      wr(ga(g, 2), '1);
      wr(ga(g, 3), 8'hA5);
    end
    wr(5'h1E, '1);
    wr(5'h1F, '1);
    check_state("R10 ignored writes");

    // R4 data stored while not an output
    load(0, '1); load(5, '0);
    wr(ga(1, 1), '1);
    wr(ga(2, 1), '1);
    wr(ga(2, 0), 8'h96);
    check_pads("R4 oe off");
    wr(ga(1, 0), '1);
    chk("R4 stored level", 32'(pad_do_o), 32'h96);
    check_pads("R4 oe on");

    // R3 R7: function select sweep, each pin through all four codes
    periph_out_i = 32'hC3A5_5A3C;
    periph_oe_i  = 32'h0FF0_33CC;
    load(0, '0);
    for (int f = 0; f < 4; f++) begin
      for (int odv = 0; odv < 2; odv++) begin
        wr(5'h1C, f[0] ? 8'hFF : 8'h00);
        wr(5'h1D, f[1] ? 8'hFF : 8'h00);
        load(5, odv ? 8'hFF : 8'h00);
        check_pads(odv ? "R7 od per-function" : "R3 per-function");
      end
    end

    // R3 R4 R7: random mixed sweep
    for (int it = 0; it < 200; it++) begin
      periph_out_i = $urandom;
      periph_oe_i  = $urandom;
      load(0, N'($urandom));
      load(1, N'($urandom));
      load(2, N'($urandom));
      load(5, N'($urandom));
      wr(5'h1C, N'($urandom));
      wr(5'h1D, N'($urandom));
      check_pads("R3/R7 mixed");
    end

    // R9 two-flop pad sampling, independent of ownership
    for (int it = 0; it < 8; it++) begin
      logic [N-1:0] old_v = pad_i;
      logic [N-1:0] new_v = N'(8'h3B * (it + 1)) ^ 8'h81;
      load(0, it[0] ? 8'hFF : 8'h00);
      @(negedge clk);
      old_v = pad_i;
      pad_i = new_v;
      rd(5'h1E, v); chk("R9 zero edges", 32'(v), 32'(old_v));
      @(negedge clk);
      rd(5'h1E, v); chk("R9 one edge", 32'(v), 32'(old_v));
      @(negedge clk);
      rd(5'h1E, v); chk("R9 two edges", 32'(v), 32'(new_v));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule